// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the memory-controller side and brings SDRAM devices from power-on to normal operation. After reset, nothing happens until a start strobe arrives. The block then waits a parameterized settle time. Next it issues a NOP, holds off for a fixed gap and issues precharge-all, followed by the row-precharge delay. It then issues eight auto-refresh (CBR) commands, each followed by the row-cycle delay. Last comes a single mode-register-set command, which carries the mode word on the address bus, and a short gap before normal mode.

The controller command mode is shown as a 3-bit code. The matching SDRAM control pins are decoded from it, and they are driven only in the single cycle in which a command is issued. Periodic refresh stays off through the whole sequence. It is switched on, together with the done flag, one cycle after normal mode is entered.

The CAS latency select is captured with the start strobe. Any value other than 2 selects latency 3. The mode word is placed on the address bus shifted up by three bit positions. All waits are cycle counts derived from parameters, with the settle time given in microseconds and scaled by the clock frequency in MHz.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is held, and after its release until a start strobe, the outputs show command code 1 (NOP mode) with no command issued, all four control pins high, address zero, and done and refresh-enable low.
- R2: No command is issued before a start strobe. After the strobe is sampled, the first command, a NOP, is issued exactly CLK_MHZ*SETTLE_US cycles later.
- R3: After the NOP, exactly NOP_GAP_CYC idle cycles pass before precharge-all (code 2) is issued.
- R4: After precharge-all, exactly TRP_CYC idle cycles pass before the first auto-refresh (code 4).
- R5: Exactly AREF_COUNT (default 8) auto-refresh commands are issued, each followed by exactly TRC_CYC idle cycles.
- R6: One mode-register-set (code 3) follows the last refresh gap. After MSET_GAP_CYC idle cycles the code becomes 0 (normal), and no further command is ever issued.
- R7: During mode-register-set the address carries the mode word shifted left by 3. The mode word has burst length 010 in bits 2:0, interleaved type 1 in bit 3, the CAS code in bits 6:4, and zeros in bits 11:7. This gives 0x1D0 for CAS 3 and 0x150 for CAS 2. In every other cycle the address is zero.
- R8: The CAS select is captured with the start strobe. The values 0, 1 and 3 all produce the CAS-3 word (0x1D0), so CAS codes other than 010 and 011 never appear.
- R9: The command code is never 5, 6 or 7. The pins {cs_n,ras_n,cas_n,we_n} are 0111 for NOP, 0010 for precharge-all, 0001 for refresh and 0000 for mode set, and 1111 in all non-issue cycles.
- R10: Refresh-enable and done are low until normal mode is entered. Both rise one cycle after the code first shows 0, and both stay high.
- R11: A start strobe during the sequence or after completion changes neither the timing, nor the mode word, nor the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, honoured only while idle |
| cas_lat_i | input | 2 | CAS latency select (2 or 3; others mean 3) |
| cmd_code_o | output | 3 | Controller command mode code |
| cmd_issue_o | output | 1 | High in the cycle a command goes to the devices |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | Address bus carrying the shifted mode word |
| refresh_en_o | output | 1 | Periodic refresh permitted |
| init_done_o | output | 1 | Initialization complete |

## Verification
The full sequence is run four times from reset with the default timing, using CAS selects 3 and 2, one reserved value, and one random value. In every cycle, the outputs are compared with a schedule computed from the parameters. The CAS 2 and CAS 3 runs tell the two mode-word offsets apart, and the reserved-value run shows that the fallback is to latency 3. Two of the runs scatter random start strobes across the whole sequence and beyond completion, which would expose any restart or shift in the cycle counts. An idle stretch before the first strobe confirms that nothing is issued early.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  typedef enum logic [2:0] {
    CMD_NORMAL  = 3'd0,
    CMD_NOP     = 3'd1,
    CMD_PALL    = 3'd2,
    CMD_MODESET = 3'd3,
    CMD_AUTOREF = 3'd4
  } cmd_code_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_NOP,
    ST_NOP_WAIT,
    ST_PALL,
    ST_PALL_WAIT,
    ST_AREF,
    ST_AREF_WAIT,
    ST_MSET,
    ST_MSET_WAIT,
    ST_NORMAL,
    ST_READY
  } seq_state_e;

  // Controller command mode held in each state
  function automatic cmd_code_e state_code(input seq_state_e st);
    case (st)
      ST_PALL, ST_PALL_WAIT:   state_code = CMD_PALL;
      ST_AREF, ST_AREF_WAIT:   state_code = CMD_AUTOREF;
      ST_MSET, ST_MSET_WAIT:   state_code = CMD_MODESET;
      ST_NORMAL, ST_READY:     state_code = CMD_NORMAL;
      default:                 state_code = CMD_NOP;
    endcase
  endfunction

  function automatic logic is_issue_state(input seq_state_e st);
    is_issue_state = (st == ST_NOP) || (st == ST_PALL) ||
                     (st == ST_AREF) || (st == ST_MSET);
  endfunction

  function automatic logic is_wait_state(input seq_state_e st);
    is_wait_state = (st == ST_SETTLE) || (st == ST_NOP_WAIT) ||
                    (st == ST_PALL_WAIT) || (st == ST_AREF_WAIT) ||
                    (st == ST_MSET_WAIT);
  endfunction

endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/seq_wait_timer.sv
module seq_wait_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             run_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = val_i;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R5: a running count only moves downward by one per cycle
  assert_timer_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/seq_mode_word.sv
module seq_mode_word #(
  parameter int         ADDR_W           = 16,
  parameter int         MODE_SHIFT       = 3,
  parameter logic [2:0] BURST_LEN        = 3'b010,
  parameter logic       BURST_INTERLEAVE = 1'b1,
  parameter logic       WRITE_SINGLE     = 1'b0
) (
  input  logic [1:0]        cas_lat_i,
  output logic [ADDR_W-1:0] mset_addr_o
);
  localparam int MODE_W = 12;

  logic [2:0]        cas_field;
  logic [MODE_W-1:0] mode_word;

  always_comb begin
    cas_field = (cas_lat_i == 2'd2) ? 3'b010 : 3'b011;
    mode_word = {2'b00, WRITE_SINGLE, 2'b00, cas_field, BURST_INTERLEAVE, BURST_LEN};
  end

  assign mset_addr_o = ADDR_W'(mode_word) << MODE_SHIFT;
endmodule

// File: rtl/seq_cmd_pins.sv
module seq_cmd_pins
  import sdinit_pkg::*;
(
  input  cmd_code_e code_i,
  input  logic      issue_i,
  output logic      cs_n_o,
  output logic      ras_n_o,
  output logic      cas_n_o,
  output logic      we_n_o
);
  logic [3:0] pins;

  always_comb begin
    pins = 4'b1111;
    if (issue_i) begin
      case (code_i)
        CMD_NOP:     pins = 4'b0111;
        CMD_PALL:    pins = 4'b0010;
        CMD_AUTOREF: pins = 4'b0001;
        CMD_MODESET: pins = 4'b0000;
        default:     pins = 4'b1111;
      endcase
    end
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = pins;
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdinit_pkg::*;
#(
  parameter int         CLK_MHZ          = 100,
  parameter int         SETTLE_US        = 200,
  parameter int         NOP_GAP_CYC      = 200,
  parameter int         TRP_CYC          = 3,
  parameter int         TRC_CYC          = 7,
  parameter int         MSET_GAP_CYC     = 2,
  parameter int         AREF_COUNT       = 8,
  parameter int         ADDR_W           = 16,
  parameter logic [2:0] BURST_LEN        = 3'b010,
  parameter logic       BURST_INTERLEAVE = 1'b1,
  parameter logic       WRITE_SINGLE     = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        cas_lat_i,
  output logic [2:0]        cmd_code_o,
  output logic              cmd_issue_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              refresh_en_o,
  output logic              init_done_o
);
  localparam int MODE_SHIFT = 3;
  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
  localparam int MAX_A      = (SETTLE_CYC > NOP_GAP_CYC) ? SETTLE_CYC : NOP_GAP_CYC;
  localparam int MAX_B      = (TRP_CYC > TRC_CYC) ? TRP_CYC : TRC_CYC;
  localparam int MAX_C      = (MAX_B > MSET_GAP_CYC) ? MAX_B : MSET_GAP_CYC;
  localparam int WAIT_MAX   = (MAX_A > MAX_C) ? MAX_A : MAX_C;
  localparam int CNT_W      = $clog2(WAIT_MAX + 1);
  localparam int AREF_W     = $clog2(AREF_COUNT + 1);

  logic        rst_n_s;
  seq_state_e  st_q, st_d;
  logic [AREF_W-1:0] aref_q, aref_d;
  logic        aref_en;
  logic [1:0]  cas_q;
  logic        cas_en;
  logic        tmr_load, tmr_zero, tmr_run;
  logic [CNT_W-1:0] tmr_val;
  logic        ref_en_q, ref_en_set;
  logic [ADDR_W-1:0] mset_addr;
  cmd_code_e   code;

  seq_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  seq_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .run_i  (tmr_run),
    .zero_o (tmr_zero)
  );

  seq_mode_word #(
    .ADDR_W           (ADDR_W),
    .MODE_SHIFT       (MODE_SHIFT),
    .BURST_LEN        (BURST_LEN),
    .BURST_INTERLEAVE (BURST_INTERLEAVE),
    .WRITE_SINGLE     (WRITE_SINGLE)
  ) u_mode (
    .cas_lat_i   (cas_q),
    .mset_addr_o (mset_addr)
  );

  // Next-state logic
  always_comb begin
    st_d       = st_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    aref_en    = 1'b0;
    aref_d     = aref_q;
    cas_en     = 1'b0;
    ref_en_set = 1'b0;
    tmr_run    = is_wait_state(st_q);
    case (st_q)
      ST_IDLE: if (start_i) begin
        st_d     = ST_SETTLE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(SETTLE_CYC - 1);
        cas_en   = 1'b1;
      end
      ST_SETTLE:   if (tmr_zero) st_d = ST_NOP;
      ST_NOP: begin
        st_d     = ST_NOP_WAIT;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(NOP_GAP_CYC - 1);
      end
      ST_NOP_WAIT: if (tmr_zero) st_d = ST_PALL;
      ST_PALL: begin
        st_d     = ST_PALL_WAIT;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(TRP_CYC - 1);
      end
      ST_PALL_WAIT: if (tmr_zero) begin
        st_d    = ST_AREF;
        aref_en = 1'b1;
        aref_d  = '0;
      end
      ST_AREF: begin
        st_d     = ST_AREF_WAIT;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(TRC_CYC - 1);
        aref_en  = 1'b1;
        aref_d   = aref_q + 1'b1;
      end
      ST_AREF_WAIT: if (tmr_zero) begin
        st_d = (aref_q == AREF_W'(AREF_COUNT)) ? ST_MSET : ST_AREF;
      end
      ST_MSET: begin
        st_d     = ST_MSET_WAIT;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(MSET_GAP_CYC - 1);
      end
      ST_MSET_WAIT: if (tmr_zero) st_d = ST_NORMAL;
      ST_NORMAL: begin
        st_d       = ST_READY;
        ref_en_set = 1'b1;
      end
      default: st_d = ST_READY;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) st_q <= ST_IDLE;
    else          st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     aref_q <= '0;
    else if (aref_en) aref_q <= aref_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    cas_q <= 2'd3;
    else if (cas_en) cas_q <= cas_lat_i;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)        ref_en_q <= 1'b0;
    else if (ref_en_set) ref_en_q <= 1'b1;
  end

  // Outputs decoded from registered state
  assign code        = state_code(st_q);
  assign cmd_code_o  = code;
  assign cmd_issue_o = is_issue_state(st_q);
  assign addr_o      = (st_q == ST_MSET) ? mset_addr : '0;
  assign init_done_o = (st_q == ST_READY);
  assign refresh_en_o = ref_en_q;

  seq_cmd_pins u_pins (
    .code_i  (code),
    .issue_i (cmd_issue_o),
    .cs_n_o  (cs_n_o),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .we_n_o  (we_n_o)
  );

  assert_code_legal_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    cmd_code_o <= 3'd4);

  assert_select_match_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    cmd_issue_o == !cs_n_o);

  assert_mset_addr_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd_issue_o && (cmd_code_o == 3'd3)) |->
      ((addr_o == ADDR_W'(16'h1D0)) || (addr_o == ADDR_W'(16'h150))));

  assert_addr_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(cmd_issue_o && (cmd_code_o == 3'd3)) |-> (addr_o == '0));

  assert_refresh_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    refresh_en_o |-> (!cmd_issue_o && (cmd_code_o == 3'd0)));

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    init_done_o |=> (init_done_o && refresh_en_o));

  assert_aref_bound_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    aref_q <= AREF_W'(AREF_COUNT));

  assert_cas_held_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st_q != ST_IDLE) |=> $stable(cas_q));
endmodule

// File: tb/sdram_pwrup_seq_tb.sv
module sdram_pwrup_seq_tb;
  localparam int CLK_MHZ = 100, SETTLE_US = 200, NOP_GAP = 200;
  localparam int TRP = 3, TRC = 7, MGAP = 2, NREF = 8, AW = 16;
  localparam int T_NOP  = CLK_MHZ * SETTLE_US;
  localparam int T_PRE  = T_NOP + 1 + NOP_GAP;
  localparam int T_REF0 = T_PRE + 1 + TRP;
  localparam int T_MRS  = T_REF0 + NREF * (1 + TRC);
  localparam int T_NORM = T_MRS + 1 + MGAP;
  localparam int T_DONE = T_NORM + 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] cas_sel = 2'd3;
  logic [2:0] code;
  logic issue, cs_n, ras_n, cas_n, we_n, ref_en, done;
  logic [AW-1:0] addr;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sdram_pwrup_seq #(
    .CLK_MHZ(CLK_MHZ), .SETTLE_US(SETTLE_US), .NOP_GAP_CYC(NOP_GAP),
    .TRP_CYC(TRP), .TRC_CYC(TRC), .MSET_GAP_CYC(MGAP), .AREF_COUNT(NREF),
    .ADDR_W(AW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cas_lat_i(cas_sel),
    .cmd_code_o(code), .cmd_issue_o(issue), .cs_n_o(cs_n), .ras_n_o(ras_n),
    .cas_n_o(cas_n), .we_n_o(we_n), .addr_o(addr), .refresh_en_o(ref_en),
    .init_done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected command code issued in cycle t, or -1 for none
  function automatic int exp_issue(input int t);
    if (t == T_NOP) return 1;
    if (t == T_PRE) return 2;
    if (t == T_MRS) return 3;
    if (t >= T_REF0 && t < T_MRS && ((t - T_REF0) % (1 + TRC)) == 0) return 4;
    return -1;
  endfunction

  function automatic int exp_mode(input int t);
    if (t < T_PRE)  return 1;
    if (t < T_REF0) return 2;
    if (t < T_MRS)  return 4;
    if (t < T_NORM) return 3;
    return 0;
  endfunction

  function automatic int exp_pins(input int c);
    case (c)
      1: return 4'b0111;
      2: return 4'b0010;
      4: return 4'b0001;
      3: return 4'b0000;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic string phase_tag(input int t);
    if (t < T_NOP)  return "R2";
    if (t <= T_PRE) return "R3";
    if (t < T_REF0) return "R4";
    if (t < T_MRS)  return "R5";
    return "R6";
  endfunction

  // Idle-state outputs (R1)
  task automatic chk_idle(input string tag);
    chk(code == 3'd1, tag, code, 1);
    chk(!issue && {cs_n, ras_n, cas_n, we_n} == 4'b1111, tag, {issue, cs_n, ras_n, cas_n, we_n}, 5'b01111);
    chk(addr == '0 && !done && !ref_en, tag, {addr, done, ref_en}, 0);
  endtask

  task automatic run_seq(input logic [1:0] cas_in, input bit disturb);
    int eaddr;
    bit reserved;
    reserved = (cas_in != 2'd2) && (cas_in != 2'd3);
    eaddr = (cas_in == 2'd2) ? 32'h150 : 32'h1D0;
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk_idle("R1 after release");
    cas_sel = cas_in;
    start = 1'b1;
    @(negedge clk);
    for (int t = 0; t <= T_DONE + 20; t++) begin
      int ei, em, ea;
      ei = exp_issue(t);
      em = exp_mode(t);
      ea = (ei == 3) ? eaddr : 0;
      chk((ei >= 0) == issue && code == em[2:0], phase_tag(t), {issue, code}, {(ei >= 0), em[2:0]});
      chk({cs_n, ras_n, cas_n, we_n} == exp_pins(ei), "R9 pins", {cs_n, ras_n, cas_n, we_n}, exp_pins(ei));
      chk(int'(addr) == ea, reserved ? "R8 mode addr" : "R7 mode addr", addr, ea);
      chk(done == (t >= T_DONE) && ref_en == (t >= T_DONE), "R10 done/refresh",
          {done, ref_en}, {(t >= T_DONE), (t >= T_DONE)});
      if (disturb) begin
        start = (($urandom % 40) == 0);
        cas_sel = 2'($urandom);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    // R11: strobe after completion leaves outputs untouched
    start = 1'b1;
    cas_sel = 2'd2;
    repeat (5) @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk(done && ref_en && !issue && code == 3'd0 && addr == '0, "R11 after done",
        {done, ref_en, issue, code}, 6'b110000);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R2: nothing issued without a strobe
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (i % 50 == 0) chk(!issue && !done, "R2 no strobe", {issue, done}, 0);
    end
    run_seq(2'd3, 1'b0);
    run_seq(2'd2, 1'b1);   // R11: random strobes mid-run
    run_seq(2'd0, 1'b0);   // R8: reserved select
    run_seq(2'($urandom), 1'b1);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule